// File: doc/BRIEF.md
# Override-capable general-purpose I/O port

This block is one general-purpose I/O port of W pins (eight by default). Each pin has a direction bit and a data bit. Both are loaded from a small register bus through write strobes that all pins of the port share. Read strobes return the direction register, the data register or a sampled copy of the pad inputs. The pad is modelled as three separate signals: an input, a driven value and an output enable. A fourth signal per pin enables the pull-up.

On-chip peripherals can take over any single pin without touching the registers. They do this through four override pairs, each an enable and a value. One pair covers the pull-up, one the output enable, one the driven value and one the digital-input enable. When an enable is low, the register-based behaviour applies. Two signals are global. A pull-up disable input suppresses every register-requested pull-up, and a sleep input turns off the digital inputs of pins whose input-enable override is not set.

The gated pad value goes straight to the peripherals, without synchronisation. The same gated value also feeds a synchronizer: a latch that is transparent while the clock is low, followed by a rising-edge flip-flop. The output of that flip-flop is the pin readback.

Top module: `gpio_ovr_port`

## Requirements
- R1: An active-low asynchronous reset clears the direction register, the data register and the pin readback flop. With all override enables low, the pull-up, output-enable and driven-value outputs are then 0, and every readback returns 0.
- R2: At a rising edge with `wr_dir` high, the direction register loads `wdata`. At a rising edge with `wr_dat` high, the data register loads `wdata`. A read issued in the same cycle as a write returns the value held before that edge.
- R3: For a pin whose pull-up override enable is low, `pad_pu` is 1 only when its direction bit is 0, its data bit is 1 and `pu_off` is 0.
- R4: For a pin whose pull-up override enable is high, `pad_pu` equals its pull-up override value, whatever the direction bit, the data bit and `pu_off` hold.
- R5: `pad_oe` equals the direction override value when the direction override enable is high, and the direction register bit when it is low.
- R6: When `pad_oe` is 1, `pad_out` equals the value override when the value override enable is high, and the data register bit when it is low. When `pad_oe` is 0, `pad_out` is 0.
- R7: The digital input of a pin is enabled by the input-enable override value when that override's enable is high. When that enable is low, the input is enabled exactly while `sleep` is 0. A disabled input presents 0 to `periph_di` and to the synchronizer.
- R8: `periph_di` is the gated pad input with no register in its path, so it follows `pad_in` within the same cycle.
- R9: A pad value applied while the clock is high is not visible on the pin readback before the next rising edge, and is visible after it.
- R10: `rdata` is the bitwise OR of the direction register (when `rd_dir` is high), the data register (when `rd_dat` is high) and the pin readback (when `rd_pin` is high). It is 0 when no read strobe is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_dir | input | 1 | Load direction register from wdata |
| wr_dat | input | 1 | Load data register from wdata |
| rd_dir | input | 1 | Select direction register onto rdata |
| rd_dat | input | 1 | Select data register onto rdata |
| rd_pin | input | 1 | Select synchronized pin value onto rdata |
| wdata | input | W | Register write data |
| rdata | output | W | Register read data |
| sleep | input | 1 | Global input-disable request |
| pu_off | input | 1 | Global disable of register-requested pull-ups |
| pu_ovr_en | input | W | Pull-up override enable per pin |
| pu_ovr_val | input | W | Pull-up override value per pin |
| dir_ovr_en | input | W | Output-enable override enable per pin |
| dir_ovr_val | input | W | Output-enable override value per pin |
| val_ovr_en | input | W | Driven-value override enable per pin |
| val_ovr_val | input | W | Driven-value override value per pin |
| ie_ovr_en | input | W | Input-enable override enable per pin |
| ie_ovr_val | input | W | Input-enable override value per pin |
| pad_in | input | W | Pad input level |
| pad_out | output | W | Pad driven value |
| pad_oe | output | W | Pad output-driver enable |
| pad_pu | output | W | Pad pull-up enable |
| periph_di | output | W | Unsynchronized gated input for peripherals |

## Verification
Several things can land in the same cycle and must be checked together. A register write can coincide with an override that masks the bit being written, and with a read of that same register. A pad change can also coincide with a pin read. The random phase raises the write and read strobes independently in every cycle, together with random override enables and values. A reference model takes the pre-edge register values for the same-cycle read and the post-edge values for the next cycle. The same model checks that a pin read issued in the cycle of a pad change still returns the earlier sample.

// File: rtl/gpio_ovr_port.sv
module gpio_ovr_port #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_dir,
  input  logic         wr_dat,
  input  logic         rd_dir,
  input  logic         rd_dat,
  input  logic         rd_pin,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] rdata,
  input  logic         sleep,
  input  logic         pu_off,
  input  logic [W-1:0] pu_ovr_en,
  input  logic [W-1:0] pu_ovr_val,
  input  logic [W-1:0] dir_ovr_en,
  input  logic [W-1:0] dir_ovr_val,
  input  logic [W-1:0] val_ovr_en,
  input  logic [W-1:0] val_ovr_val,
  input  logic [W-1:0] ie_ovr_en,
  input  logic [W-1:0] ie_ovr_val,
  input  logic [W-1:0] pad_in,
  output logic [W-1:0] pad_out,
  output logic [W-1:0] pad_oe,
  output logic [W-1:0] pad_pu,
  output logic [W-1:0] periph_di
);

  logic [W-1:0] dir_q, dat_q, pin_q, sync_lat, in_en, gated_in, drv_val;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= '0;
      dat_q <= '0;
    end else begin
      if (wr_dir) dir_q <= wdata;
      if (wr_dat) dat_q <= wdata;
    end
  end

  for (genvar i = 0; i < W; i++) begin : g_pin
    assign pad_pu[i]  = pu_ovr_en[i]  ? pu_ovr_val[i]  : (~dir_q[i] & dat_q[i] & ~pu_off);
    assign pad_oe[i]  = dir_ovr_en[i] ? dir_ovr_val[i] : dir_q[i];
    assign drv_val[i] = val_ovr_en[i] ? val_ovr_val[i] : dat_q[i];
    assign in_en[i]   = ie_ovr_en[i]  ? ie_ovr_val[i]  : ~sleep;
  end

  assign pad_out   = pad_oe & drv_val;
  assign gated_in  = pad_in & in_en;
  assign periph_di = gated_in;

  always_latch begin
    if (!clk) sync_lat <= gated_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_q <= '0;
    else        pin_q <= sync_lat;
  end

  assign rdata = ({W{rd_dir}} & dir_q) | ({W{rd_dat}} & dat_q) | ({W{rd_pin}} & pin_q);

endmodule

// File: rtl/gpio_ovr_port_chk.sv
module gpio_ovr_port_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         wr_dir,
  input logic         wr_dat,
  input logic         rd_dir,
  input logic         rd_dat,
  input logic         rd_pin,
  input logic [W-1:0] wdata,
  input logic [W-1:0] rdata,
  input logic         sleep,
  input logic         pu_off,
  input logic [W-1:0] pu_ovr_en,
  input logic [W-1:0] pu_ovr_val,
  input logic [W-1:0] dir_ovr_en,
  input logic [W-1:0] dir_ovr_val,
  input logic [W-1:0] val_ovr_en,
  input logic [W-1:0] val_ovr_val,
  input logic [W-1:0] ie_ovr_en,
  input logic [W-1:0] ie_ovr_val,
  input logic [W-1:0] pad_in,
  input logic [W-1:0] pad_out,
  input logic [W-1:0] pad_oe,
  input logic [W-1:0] pad_pu,
  input logic [W-1:0] periph_di
);

  logic armed;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  a_r2_dir_load: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dir |=> ((pad_oe & ~dir_ovr_en) == ($past(wdata) & ~dir_ovr_en)));

  a_r4_pu_override: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_pu & pu_ovr_en) == (pu_ovr_val & pu_ovr_en));

  a_r6_idle_driver_low: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_out & ~pad_oe) == '0);

  a_r7_sleep_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |-> ((periph_di & ~ie_ovr_en) == '0));

  a_r9_pin_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && rd_pin && !rd_dir && !rd_dat) |-> (rdata == $past(periph_di)));

endmodule

bind gpio_ovr_port gpio_ovr_port_chk #(.W(W)) chk_i (.*);

// File: tb/gpio_ovr_port_tb.sv
module gpio_ovr_port_tb_top;
  localparam int W = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_dir = 0, wr_dat = 0, rd_dir = 0, rd_dat = 0, rd_pin = 0, sleep = 0, pu_off = 0;
  logic [W-1:0] wdata = '0, pu_ovr_en = '0, pu_ovr_val = '0, dir_ovr_en = '0, dir_ovr_val = '0;
  logic [W-1:0] val_ovr_en = '0, val_ovr_val = '0, ie_ovr_en = '0, ie_ovr_val = '0, pad_in = '0;
  logic [W-1:0] rdata, pad_out, pad_oe, pad_pu, periph_di;
  logic [W-1:0] m_dir = '0, m_dat = '0, m_pin = '0;
  int total = 0, bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  gpio_ovr_port #(.W(W)) dut_i (.*);

  function automatic logic [W-1:0] e_pu();
    return (pu_ovr_en & pu_ovr_val) | (~pu_ovr_en & ~m_dir & m_dat & {W{~pu_off}});
  endfunction
  function automatic logic [W-1:0] e_oe();
    return (dir_ovr_en & dir_ovr_val) | (~dir_ovr_en & m_dir);
  endfunction
  function automatic logic [W-1:0] e_out();
    return e_oe() & ((val_ovr_en & val_ovr_val) | (~val_ovr_en & m_dat));
  endfunction
  function automatic logic [W-1:0] e_di();
    return pad_in & ((ie_ovr_en & ie_ovr_val) | (~ie_ovr_en & {W{~sleep}}));
  endfunction
  function automatic logic [W-1:0] e_rd();
    return ({W{rd_dir}} & m_dir) | ({W{rd_dat}} & m_dat) | ({W{rd_pin}} & m_pin);
  endfunction

  task automatic chk(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    logic [W-1:0] nd;
    nd = e_di();
    @(posedge clk);
    if (wr_dir) m_dir = wdata;
    if (wr_dat) m_dat = wdata;
    m_pin = nd;
    #1;
  endtask

  task automatic check_all(string tag);
    chk({tag, " R3/R4 pad_pu"}, pad_pu, e_pu());
    chk({tag, " R5 pad_oe"}, pad_oe, e_oe());
    chk({tag, " R6 pad_out"}, pad_out, e_out());
    chk({tag, " R7/R8 periph_di"}, periph_di, e_di());
    chk({tag, " R10 rdata"}, rdata, e_rd());
  endtask

  initial begin
    void'($urandom(32'h1d2c3b4a));
    pad_in = 8'h3C;
    repeat (3) @(posedge clk);
    #1;
    rd_dir = 1; #1 chk("R1 dir after reset", rdata, 8'h00);
    rd_dir = 0; rd_dat = 1; #1 chk("R1 dat after reset", rdata, 8'h00);
    rd_dat = 0; rd_pin = 1; #1 chk("R1 pin after reset", rdata, 8'h00);
    chk("R1 pad_oe", pad_oe, 8'h00);
    chk("R1 pad_pu", pad_pu, 8'h00);
    chk("R1 pad_out", pad_out, 8'h00);
    m_pin = '0;
    @(posedge clk); #1;
    rst_n = 1'b1;
    rd_pin = 0;
    tick();

    // R2 write then read; same-cycle read returns old value
    wr_dat = 1; wdata = 8'hF0; rd_dat = 1; #1;
    chk("R2 same-cycle read old", rdata, 8'h00);
    tick(); wr_dat = 0; #1;
    chk("R2 dat loaded", rdata, 8'hF0);
    rd_dat = 0;
    // R3 pull-up disable corner
    chk("R3 pull-up on", pad_pu, 8'hF0);
    pu_off = 1; #1 chk("R3 pu_off suppresses", pad_pu, 8'h00);
    pu_ovr_en = 8'h81; pu_ovr_val = 8'h01; #1 chk("R4 override wins", pad_pu, 8'h01);
    pu_off = 0; pu_ovr_en = 0; pu_ovr_val = 0;
    wr_dir = 1; wdata = 8'h30; tick(); wr_dir = 0; #1;
    chk("R3 output pins lose pull-up", pad_pu, 8'hC0);
    chk("R6 driven from data", pad_out, 8'h30);
    val_ovr_en = 8'h10; val_ovr_val = 8'h00; #1 chk("R6 value override", pad_out, 8'h20);
    dir_ovr_en = 8'h21; dir_ovr_val = 8'h01; #1 chk("R5 direction override", pad_oe, 8'h11);
    chk("R6 forced-input pin not driven", pad_out, 8'h00);
    val_ovr_en = 0; dir_ovr_en = 0; dir_ovr_val = 0;

    // R8/R9 latency
    rd_pin = 1; pad_in = 8'hA5; #1;
    chk("R8 periph_di immediate", periph_di, 8'hA5);
    chk("R9 not yet visible", rdata, 8'h3C);
    tick();
    chk("R9 visible after edge", rdata, 8'hA5);
    sleep = 1; #1 chk("R7 sleep gates input", periph_di, 8'h00);
    ie_ovr_en = 8'h0F; ie_ovr_val = 8'h0F; #1 chk("R7 override keeps input", periph_di, 8'h05);
    tick();
    chk("R7 synchronizer sees gated value", rdata, 8'h05);
    sleep = 0; ie_ovr_en = 0; ie_ovr_val = 0; rd_pin = 0;
    tick();

    for (int n = 0; n < 3000; n++) begin
      wr_dir = $urandom_range(0, 3) == 0;
      wr_dat = $urandom_range(0, 3) == 0;
      rd_dir = $urandom_range(0, 1) == 0;
      rd_dat = $urandom_range(0, 1) == 0;
      rd_pin = $urandom_range(0, 1) == 0;
      wdata = W'($urandom);
      sleep = $urandom_range(0, 3) == 0;
      pu_off = $urandom_range(0, 3) == 0;
      pu_ovr_en = W'($urandom & $urandom);   pu_ovr_val = W'($urandom);
      dir_ovr_en = W'($urandom & $urandom);  dir_ovr_val = W'($urandom);
      val_ovr_en = W'($urandom & $urandom);  val_ovr_val = W'($urandom);
      ie_ovr_en = W'($urandom & $urandom);   ie_ovr_val = W'($urandom);
      pad_in = W'($urandom);
      #1;
      check_all("rand R2/R9");
      tick();
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule